// File: doc/BRIEF.md
# Page-Write Load and Program Controller

This block is the device-side controller of a byte-alterable nonvolatile memory model. A host drives a synchronous bus made of active-low chip enable, write enable and output enable strobes, an address and an 8-bit data bus. Byte loads go into a page buffer. Each load restarts a load window counted in clock cycles. When the window runs out with no new load, the controller starts an internal program cycle of fixed length. At the end of that cycle it copies every loaded byte into the cell array, which is modelled as a register array that resets to the erased value 8'hFF.

While the program cycle runs, reads return a status byte instead of array data. Bit 7 is the complement of bit 7 of the last byte loaded. Bit 6 changes on every read. A host can therefore poll either bit to find out when the cycle has finished. The address width, the in-page offset width, the load window and the program duration are all parameters.

The controller has three states:
- `PW_IDLE`: no page operation is open.
- `PW_LOAD`: a page operation is open and bytes are being collected.
- `PW_PROG`: the internal program cycle is running.

It has four transitions:
- *open*, `PW_IDLE`→`PW_LOAD`, on the first load.
- *reload*, `PW_LOAD`→`PW_LOAD`, on any later load.
- *expire*, `PW_LOAD`→`PW_PROG`, when the window runs out.
- *commit*, `PW_PROG`→`PW_IDLE`, when the program count ends.

Top module: `pagewr_ctrl`

## Requirements
- R1: A byte load starts on the first clock edge at which `ce_n`=0, `we_n`=0 and `oe_n`=1 are sampled after a cycle in which that condition was false. A strobe held for several cycles counts as one load. Any other combination (output enable low, write enable high, or chip enable high) loads nothing.
- R2: If no new load starts, the *expire* transition happens at the clock edge exactly `WIN_CYC` edges after the edge of the last load. `busy` is high from the next cycle on. A program cycle never starts with an empty page buffer.
- R3: A load that starts within `WIN_CYC` edges of the previous load, including at exactly `WIN_CYC` edges, joins the open page operation and restarts the window. The number of loads in one operation has no limit. A second load to the same offset replaces the first.
- R4: The page is `addr[ADDR_W-1:7]` and the in-page offset is `addr[6:0]`, so one page holds 128 bytes. All 128 offsets of a page can be loaded in one operation.
- R5: A load in `PW_LOAD` whose page differs from the page of the opening load is ignored. It sets `page_err`, which stays at 1 until reset.
- R6: The program cycle lasts `PROG_CYC` edges. `busy` falls after the edge that ends it. At that edge only the loaded offsets of the page take their new values, and every other byte of the array is unchanged.
- R7: Loads that start while `busy` is high are ignored and change no array byte.
- R8: A read that starts while `busy` is high returns `{~L[7], T, 6'b0}`, where L is the last byte loaded. T is 1 for the first read after *expire* and inverts on every later read that starts during the cycle.
- R9: A read is sampled when `ce_n`=0, `oe_n`=0 and `we_n`=1. `rdata` and `rdata_en` are registered, so they are valid one cycle after the edge that samples the read. When `busy` is low, `rdata` is the array byte at `addr`.
- R10: `rdata_en` is 1 only in the cycle after a read was sampled. When chip enable is high, or when output and write enable are both low, `rdata_en`=0 and `rdata`=0.
- R11: After reset the state is `PW_IDLE`, `busy`=0, `page_err`=0, `rdata_en`=0 and every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address (page and offset) |
| wdata | input | 8 | Data for a byte load |
| rdata | output | 8 | Read data or status byte, registered |
| rdata_en | output | 1 | Data output enable, high while read data is driven |
| busy | output | 1 | High during the internal program cycle |
| page_err | output | 1 | Sticky flag: a load targeted a foreign page |

## Verification
The bench spaces loads at gaps up to exactly `WIN_CYC` edges. A window compare that is off by one would fire *expire* early and split the page, and the bench catches this as a missing byte and a `busy` edge in the wrong cycle. It writes during `busy` and reloads an offset already loaded. A design that let writes through the program lock, or kept the first value of a reloaded offset, would read back the wrong bytes. It polls three times during the program cycle and checks the inverted bit 7 and the 1-0-1 pattern on bit 6. It also checks that a foreign-page load, an inhibited strobe combination and the bytes of the page that were never loaded all leave the array unchanged, and that a full 128-byte page is accepted.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_LOAD = 2'd1,
        PW_PROG = 2'd2
    } pw_state_e;

    localparam int unsigned PW_DW = 8;
    localparam logic [PW_DW-1:0] PW_ERASED = 8'hFF;
endpackage

// File: rtl/pw_timer.sv
module pw_timer #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the count never passes its terminal value
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
    parameter int unsigned OFS_W = 7,
    parameter int unsigned DW    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [OFS_W-1:0]              ofs,
    input  logic [DW-1:0]                 din,
    input  logic                          clr,
    output logic [(1<<OFS_W)*DW-1:0]      data_flat,
    output logic [(1<<OFS_W)-1:0]         vld
);
    localparam int unsigned NB = 1 << OFS_W;

    for (genvar g = 0; g < NB; g++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (wr && (ofs == OFS_W'(g))) begin
                slot_q <= din;
            end
        end
        assign data_flat[g*DW +: DW] = slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (clr) begin
            vld <= '0;
        end else if (wr) begin
            vld[ofs] <= 1'b1;
        end
    end
endmodule

// File: rtl/pw_array.sv
module pw_array #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned OFS_W  = 7
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   commit,
    input  logic [ADDR_W-OFS_W-1:0]                page,
    input  logic [(1<<OFS_W)*pw_pkg::PW_DW-1:0]    buf_flat,
    input  logic [(1<<OFS_W)-1:0]                  vld,
    input  logic [ADDR_W-1:0]                      raddr,
    output logic [pw_pkg::PW_DW-1:0]               rd
);
    import pw_pkg::*;

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned NB    = 1 << OFS_W;

    logic [PW_DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= PW_ERASED;
            end
        end else if (commit) begin
            for (int i = 0; i < NB; i++) begin
                if (vld[i]) begin
                    mem[{page, OFS_W'(i)}] <= buf_flat[i*PW_DW +: PW_DW];
                end
            end
        end
    end

    assign rd = mem[raddr];
endmodule

// File: rtl/pagewr_ctrl.sv
module pagewr_ctrl #(
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned OFS_W    = 7,
    parameter int unsigned WIN_CYC  = 20000,
    parameter int unsigned PROG_CYC = 600000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rdata_en,
    output logic              busy,
    output logic              page_err
);
    import pw_pkg::*;

    localparam int unsigned PAGE_W = ADDR_W - OFS_W;
    localparam int unsigned NB     = 1 << OFS_W;

    pw_state_e state, nxt;

    logic wr_cond, rd_cond, wr_q, rd_q, wr_start, rd_start;
    logic [PAGE_W-1:0] page_q;
    logic [7:0]        last_q;
    logic              err_q, tog_q;
    logic [7:0]        rdata_q;
    logic              rden_q;

    logic buf_wr, page_open, page_bad, enter_prog;
    logic win_clear, win_run, win_done;
    logic prog_clear, prog_run, prog_done;
    logic [NB*PW_DW-1:0] buf_flat;
    logic [NB-1:0]       vld;
    logic [7:0]          arr_rd;

    assign wr_cond  = !ce_n && !we_n && oe_n;
    assign rd_cond  = !ce_n && !oe_n && we_n;
    assign wr_start = wr_cond && !wr_q;
    assign rd_start = rd_cond && !rd_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PW_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            PW_IDLE: if (wr_start) nxt = PW_LOAD;            // open
            PW_LOAD: begin
                if (wr_start)      nxt = PW_LOAD;            // reload
                else if (win_done) nxt = PW_PROG;            // expire
            end
            PW_PROG: if (prog_done) nxt = PW_IDLE;           // commit
            default: nxt = PW_IDLE;
        endcase
    end

    // per-state controls
    always_comb begin
        buf_wr     = 1'b0;
        page_open  = 1'b0;
        page_bad   = 1'b0;
        enter_prog = 1'b0;
        win_clear  = 1'b0;
        win_run    = 1'b0;
        prog_clear = 1'b1;
        prog_run   = 1'b0;
        busy       = 1'b0;
        unique case (state)
            PW_IDLE: begin
                page_open = wr_start;
                buf_wr    = wr_start;
                win_clear = wr_start;
            end
            PW_LOAD: begin
                win_clear  = wr_start;
                win_run    = !wr_start;
                buf_wr     = wr_start && (addr[ADDR_W-1:OFS_W] == page_q);
                page_bad   = wr_start && (addr[ADDR_W-1:OFS_W] != page_q);
                enter_prog = !wr_start && win_done;
            end
            PW_PROG: begin
                prog_clear = 1'b0;
                prog_run   = 1'b1;
                busy       = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            page_q  <= '0;
            last_q  <= '0;
            err_q   <= 1'b0;
            tog_q   <= 1'b0;
            rdata_q <= '0;
            rden_q  <= 1'b0;
        end else begin
            wr_q   <= wr_cond;
            rd_q   <= rd_cond;
            rden_q <= rd_cond;
            if (page_open) page_q <= addr[ADDR_W-1:OFS_W];
            if (buf_wr)    last_q <= wdata;
            if (page_bad)  err_q  <= 1'b1;
            if (enter_prog) begin
                tog_q <= 1'b0;
            end else if (busy && rd_start) begin
                tog_q <= ~tog_q;
            end
            if (!rd_cond) begin
                rdata_q <= '0;
            end else if (busy) begin
                if (rd_start) rdata_q <= {~last_q[7], ~tog_q, 6'b0};
            end else begin
                rdata_q <= arr_rd;
            end
        end
    end

    assign rdata    = rdata_q;
    assign rdata_en = rden_q;
    assign page_err = err_q;

    pw_timer #(.LIMIT(WIN_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .clear(win_clear), .run(win_run), .done(win_done)
    );

    pw_timer #(.LIMIT(PROG_CYC)) u_prog (
        .clk(clk), .rst_n(rst_n), .clear(prog_clear), .run(prog_run), .done(prog_done)
    );

    pw_page_buf #(.OFS_W(OFS_W), .DW(PW_DW)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr(buf_wr), .ofs(addr[OFS_W-1:0]), .din(wdata),
        .clr(prog_done), .data_flat(buf_flat), .vld(vld)
    );

    pw_array #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(prog_done), .page(page_q),
        .buf_flat(buf_flat), .vld(vld), .raddr(addr), .rd(arr_rd)
    );

    // R5: the foreign-page flag never clears without reset
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);

    // R2: a program cycle starts only with loaded bytes
    p_prog_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (vld != '0));

    // R6: the end of programming empties the page buffer
    p_commit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (vld == '0));

    // R7: no byte enters the buffer while programming
    p_prog_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_PROG && !prog_done) |=> $stable(vld));

    // R10: a deselected chip does not drive data in the following cycle
    p_bus_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !rdata_en);
endmodule

// File: tb/tb_pagewr_ctrl.sv
`timescale 1ns/1ps
module tb_pagewr_ctrl;
    localparam int unsigned AW = 11;
    localparam int unsigned W  = 8;
    localparam int unsigned P  = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic rdata_en, busy, page_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pagewr_ctrl #(.ADDR_W(AW), .OFS_W(7), .WIN_CYC(W), .PROG_CYC(P)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en),
        .busy(busy), .page_err(page_err)
    );

    // address, data, idle gap after the load
    localparam logic [21:0] VEC [6] = '{
        {11'h180, 8'h12, 3'd0},
        {11'h183, 8'h5A, 3'd5},
        {11'h1FF, 8'h80, 3'd2},
        {11'h183, 8'hC3, 3'd6},
        {11'h190, 8'h00, 3'd1},
        {11'h1A5, 8'h7E, 3'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        d = rdata; en = rdata_en;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic en;
        do_read(a, d, en);
        chk(req, {31'd0, en}, 32'd1);
        chk(req, {24'd0, d}, {24'd0, exp});
    endtask

    initial begin
        logic [7:0] d;
        logic en;
        logic [7:0] exp;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", {31'd0, busy}, 0);
        chk("R11 page_err", {31'd0, page_err}, 0);
        chk("R11 rdata_en", {31'd0, rdata_en}, 0);
        rst_n = 1'b1;
        rd_chk("R11 erased", 11'h7FF, 8'hFF);

        // R3/R4 table walk: one page operation with gaps up to W edges
        for (int i = 0; i < 6; i++) begin
            do_write(VEC[i][21:11], VEC[i][10:3]);
            chk("R3 no early program", {31'd0, busy}, 0);
            repeat (VEC[i][2:0]) @(negedge clk);
        end
        // R2 exact expiry edge (last entry gap is 0)
        repeat (W - 1) @(negedge clk);
        chk("R2 busy before expiry", {31'd0, busy}, 0);
        @(negedge clk);
        chk("R2 busy at expiry", {31'd0, busy}, 1);
        // R8 polling: last byte 7E -> bit7=1, bit6 1,0,1
        do_read(11'h1A5, d, en);
        chk("R8 poll1", {24'd0, d}, 32'hC0);
        do_read(11'h000, d, en);
        chk("R8 poll2", {24'd0, d}, 32'h80);
        do_read(11'h1A5, d, en);
        chk("R8 poll3", {24'd0, d}, 32'hC0);
        // R7 writes during programming
        do_write(11'h1A6, 8'h11);
        do_write(11'h000, 8'h22);
        // R6 program length: 10 edges used since expiry
        repeat (P - 11) @(negedge clk);
        chk("R6 busy last cycle", {31'd0, busy}, 1);
        @(negedge clk);
        chk("R6 busy after commit", {31'd0, busy}, 0);
        // R9 readback of the table, last value per address
        for (int i = 0; i < 6; i++) begin
            exp = VEC[i][10:3];
            for (int j = i + 1; j < 6; j++)
                if (VEC[j][21:11] == VEC[i][21:11]) exp = VEC[j][10:3];
            rd_chk("R9 readback", VEC[i][21:11], exp);
        end
        rd_chk("R6 unloaded byte", 11'h181, 8'hFF);
        rd_chk("R7 ignored in page", 11'h1A6, 8'hFF);
        rd_chk("R7 ignored other", 11'h000, 8'hFF);
        chk("R5 no error yet", {31'd0, page_err}, 0);

        // R5 foreign page
        do_write(11'h200, 8'h33);
        do_write(11'h280, 8'h44);
        chk("R5 flag set", {31'd0, page_err}, 1);
        repeat (W + P + 4) @(negedge clk);
        rd_chk("R5 own page written", 11'h200, 8'h33);
        rd_chk("R5 foreign ignored", 11'h280, 8'hFF);
        chk("R5 sticky", {31'd0, page_err}, 1);

        // R1/R10 inhibited combinations
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 11'h300; wdata = 8'h55;
        @(negedge clk);
        chk("R10 no drive oe+we low", {31'd0, rdata_en}, 0);
        ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1; addr = 11'h301;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        chk("R10 ce high rdata_en", {31'd0, rdata_en}, 0);
        chk("R10 ce high rdata", {24'd0, rdata}, 0);
        oe_n = 1'b1;
        repeat (W + 2) @(negedge clk);
        chk("R1 inhibit no program", {31'd0, busy}, 0);
        rd_chk("R1 inhibit oe", 11'h300, 8'hFF);
        rd_chk("R1 inhibit ce", 11'h301, 8'hFF);

        // R4 full 128-byte page
        for (int i = 0; i < 128; i++) do_write(AW'(11'h100 + i), 8'(i) ^ 8'h5C);
        chk("R4 full page no early program", {31'd0, busy}, 0);
        repeat (W + P + 4) @(negedge clk);
        rd_chk("R4 first", 11'h100, 8'h5C);
        rd_chk("R4 middle", 11'h140, 8'h40 ^ 8'h5C);
        rd_chk("R4 last", 11'h17F, 8'h7F ^ 8'h5C);
        rd_chk("R4 neighbour page", 11'h0FF, 8'hFF);

        // R11 reset clears error flag and array
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 flag cleared", {31'd0, page_err}, 0);
        rd_chk("R11 array erased", 11'h100, 8'hFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule